// File: doc/BRIEF.md
# Serial DAC Input Register with Cascade Output

This block is the digital front end of a serial-input DAC with a 16-bit word. A host sends words over three wires: a serial clock, a serial data line and an active-low frame select. Each bit is captured on a falling edge of the serial clock while the frame select is low. Bits enter a shift register most significant bit first. A word that is complete becomes the input register contents. A separate DAC latch drives the parallel output `dac_word`, which feeds the converter.

The latch takes a new value in one of two ways. If the load strobe is low when the sixteenth bit of a frame arrives, the latch takes the new word at once. If the load strobe is high, the word waits in the input register until a falling edge on the strobe copies it across. When the cascade enable is high, the bit that leaves the top of the shift register is driven on `chain_out`. The next device's data input can then be wired to it, so that N devices are loaded with 16·N clocks in one frame.

All serial inputs are asynchronous to `clk`. They pass through a two-stage synchroniser, and edges are found in the `clk` domain. A controller with three states drives the block:
- ST_IDLE waits for the frame select to go low. Its only transition goes to ST_RECV.
- ST_RECV counts falling edges. It goes to ST_FULL on the sixteenth edge, and back to ST_IDLE if the frame ends early.
- ST_FULL keeps shifting only in cascade mode. It returns to ST_IDLE when the frame select rises.

Top module: `sdac_front`

## Requirements
- R1: Words are 16 bits long, sent MSB first. The first bit received ends up in `dac_word[15]`, and the sixteenth bit received ends up in `dac_word[0]`.
- R2: Data is sampled only on falling edges of `ser_clk`. A change on `ser_data` while `ser_clk` is low, after the falling edge, does not alter the captured bit.
- R3: Falling edges of `ser_clk` while `frame_n` is high shift nothing. Neither the input register nor `dac_word` changes.
- R4: If `load_n` is low when the sixteenth falling edge of a frame arrives, `dac_word` takes the new word.
- R5: If `load_n` is high during a transfer, `dac_word` keeps its value. A falling edge of `load_n` then copies the input register into `dac_word`. A low pulse of one `clk` period is enough.
- R6: If `frame_n` rises before sixteen bits have arrived, the partial word is dropped. The input register keeps the previous complete word, and no automatic update happens.
- R7: Two 8-bit bursts inside one frame, with `ser_clk` idle between them, give the same result as one 16-bit burst.
- R8: With `chain_en` = 1, `chain_out` carries the bit shifted out of the register. Before falling edge k (k > 16), it shows the bit received at edge k−16. Shifting goes on past sixteen bits, and the input register holds the last 16 bits received before `frame_n` rises.
- R9: With `chain_en` = 0, `chain_out` stays 0. Bits after the sixteenth in a frame are ignored, so the input register keeps the first 16 bits.
- R10: After reset, `dac_word` = 0 and `chain_out` = 0.
- R11: `dac_word` changes on the third rising edge of `clk` after the sixteenth falling edge of `ser_clk` (automatic update) or after the falling edge of `load_n` (strobe). It is unchanged after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data captured on its falling edge |
| ser_data | input | 1 | Serial data, MSB first |
| frame_n | input | 1 | Active-low frame select |
| load_n | input | 1 | Load strobe; held low for automatic update, falling edge copies input register |
| chain_en | input | 1 | Cascade enable (static) |
| chain_out | output | 1 | Cascade serial output, 0 when cascade is off |
| dac_word | output | 16 | DAC latch contents |

## Verification
A serial input edge takes effect on the third rising `clk` edge after the bench drives it, because of two synchroniser stages and one edge register. This applies to a latch update, a shift and a `chain_out` change alike. The bench model delays its view of the raw inputs by the same amount. It compares `dac_word` and `chain_out` with the model at every falling `clk` edge, half a period after the registers move. The latency check for R11 samples at the falling edges after the second and third rising edges that follow the sixteenth serial falling edge. The directed word checks wait at least six cycles after the last event.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_FULL = 2'd2
    } rx_state_e;

    // positions of the raw serial pins inside the synchroniser vector
    localparam int unsigned PIN_DATA  = 0;
    localparam int unsigned PIN_SCLK  = 1;
    localparam int unsigned PIN_FRAME = 2;
    localparam int unsigned PIN_LOAD  = 3;
    localparam int unsigned PIN_COUNT = 4;

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int unsigned    W       = 4,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] r;
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= RST_VAL;
                else        r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= RST_VAL;
                else        r <= g_stage[g-1].r;
            end
        end
    end

    assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/sdac_edge.sv
module sdac_edge #(
    parameter int unsigned  W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign fall[i] = prev_q[i] & ~lvl[i];
    end

endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    input  logic              chain_en,
    output logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] next_word,
    output logic              chain_out
);

    logic [WORD_W-1:0] sr_q;

    assign next_word = {sr_q[WORD_W-2:0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr_q <= '0;
        else if (shift_en) sr_q <= next_word;
    end

    assign word      = sr_q;
    assign chain_out = chain_en & sr_q[WORD_W-1];

endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
    import sdac_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_lvl,
    input  logic      load_lvl,
    input  logic      sclk_fall,
    input  logic      chain_en,
    output logic      shift_en,
    output logic      commit,
    output logic      auto_upd,
    output rx_state_e state_o
);

    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        shift_en = 1'b0;
        commit   = 1'b0;
        auto_upd = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!frame_lvl) begin
                    state_d = ST_RECV;
                    cnt_d   = '0;
                end
            end
            ST_RECV: begin
                if (frame_lvl) begin
                    state_d = ST_IDLE;
                end else if (sclk_fall) begin
                    shift_en = 1'b1;
                    cnt_d    = cnt_q + 1'b1;
                    if (cnt_q == LAST_BIT) begin
                        state_d  = ST_FULL;
                        commit   = 1'b1;
                        auto_upd = ~load_lvl;
                    end
                end
            end
            ST_FULL: begin
                if (frame_lvl) begin
                    state_d = ST_IDLE;
                end else if (sclk_fall && chain_en) begin
                    shift_en = 1'b1;
                    commit   = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              frame_n,
    input  logic              load_n,
    input  logic              chain_en,
    output logic              chain_out,
    output logic [WORD_W-1:0] dac_word
);

    logic [PIN_COUNT-1:0] raw_vec, syn_vec;
    logic [1:0]           fall_vec;
    logic                 frame_lvl, load_lvl, data_lvl, sclk_fall, load_fall;
    logic                 shift_en, commit, auto_upd;
    rx_state_e            state;
    logic [WORD_W-1:0]    sr_word, next_word, hold_q, latch_q;

    assign raw_vec[PIN_DATA]  = ser_data;
    assign raw_vec[PIN_SCLK]  = ser_clk;
    assign raw_vec[PIN_FRAME] = frame_n;
    assign raw_vec[PIN_LOAD]  = load_n;

    sdac_sync #(
        .W      (PIN_COUNT),
        .STAGES (SYNC_STAGES),
        .RST_VAL({PIN_COUNT{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_vec),
        .q    (syn_vec)
    );

    assign data_lvl  = syn_vec[PIN_DATA];
    assign frame_lvl = syn_vec[PIN_FRAME];
    assign load_lvl  = syn_vec[PIN_LOAD];

    sdac_edge #(
        .W      (2),
        .RST_VAL(2'b11)
    ) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({syn_vec[PIN_LOAD], syn_vec[PIN_SCLK]}),
        .fall (fall_vec)
    );

    assign sclk_fall = fall_vec[0];
    assign load_fall = fall_vec[1];

    sdac_ctrl #(
        .WORD_W(WORD_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_lvl(frame_lvl),
        .load_lvl (load_lvl),
        .sclk_fall(sclk_fall),
        .chain_en (chain_en),
        .shift_en (shift_en),
        .commit   (commit),
        .auto_upd (auto_upd),
        .state_o  (state)
    );

    sdac_shifter #(
        .WORD_W(WORD_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (data_lvl),
        .chain_en (chain_en),
        .word     (sr_word),
        .next_word(next_word),
        .chain_out(chain_out)
    );

    // input register and DAC latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            latch_q <= '0;
        end else begin
            if (commit)         hold_q  <= next_word;
            if (auto_upd)       latch_q <= next_word;
            else if (load_fall) latch_q <= hold_q;
        end
    end

    assign dac_word = latch_q;

endmodule

// File: rtl/sdac_checks.sv
module sdac_checks
    import sdac_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_lvl,
    input logic              load_fall,
    input logic              shift_en,
    input logic              auto_upd,
    input logic              chain_en,
    input rx_state_e         state,
    input logic [WORD_W-1:0] sr_word,
    input logic [WORD_W-1:0] next_word,
    input logic [WORD_W-1:0] hold_word,
    input logic [WORD_W-1:0] dac_word
);

    // R3: a high frame select stops all shifting from the next cycle
    assert_frame_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_lvl |=> !shift_en);

    // R4: automatic update loads the word completed in that cycle
    assert_auto_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        auto_upd |=> dac_word == $past(next_word));

    // R5: strobe edge copies the input register
    assert_strobe_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fall && !auto_upd) |=> dac_word == $past(hold_word));

    // R6: without an update event the latch holds
    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_fall && !auto_upd) |=> dac_word == $past(dac_word));

    // R9: full word with cascade off leaves the shift register alone
    assert_full_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_en && state == ST_FULL) |=> sr_word == $past(sr_word));

endmodule

bind sdac_front sdac_checks #(.WORD_W(WORD_W)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_lvl(frame_lvl),
    .load_fall(load_fall),
    .shift_en (shift_en),
    .auto_upd (auto_upd),
    .chain_en (chain_en),
    .state    (state),
    .sr_word  (sr_word),
    .next_word(next_word),
    .hold_word(hold_q),
    .dac_word (dac_word)
);

// File: tb/sdac_front_bench.sv
module sdac_front_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b1;
    logic        ser_data = 1'b0;
    logic        frame_n = 1'b1;
    logic        load_n = 1'b1;
    logic        chain_en = 1'b0;
    logic        chain_out;
    logic [15:0] dac_word;

    int    checks = 0;
    int    bad = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R10";

    always #10 clk = ~clk;

    sdac_front u_sdac_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .frame_n  (frame_n),
        .load_n   (load_n),
        .chain_en (chain_en),
        .chain_out(chain_out),
        .dac_word (dac_word)
    );

    // ---------------- reference model ----------------
    // each raw input is seen by the model two cycles late; edges use three-cycle-old values
    logic [3:0]  h1, h2, h3;   // {load, frame, sclk, data}
    int          m_phase;      // 0 waiting, 1 collecting, 2 word complete
    int          m_cnt;
    logic [15:0] m_sr, m_hold, m_latch, old_hold;
    logic        m_chain;
    bit          s_fall, l_fall, did_auto;

    assign m_chain = chain_en & m_sr[15];

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = 4'hF; h2 = 4'hF; h3 = 4'hF;
            m_phase = 0; m_cnt = 0;
            m_sr = '0; m_hold = '0; m_latch = '0;
        end else begin
            s_fall   = h3[1] && !h2[1];
            l_fall   = h3[3] && !h2[3];
            did_auto = 1'b0;
            old_hold = m_hold;
            if (m_phase == 0) begin
                if (!h2[2]) begin m_phase = 1; m_cnt = 0; end
            end else if (h2[2]) begin
                m_phase = 0;
            end else if (s_fall) begin
                if (m_phase == 1) begin
                    m_sr  = {m_sr[14:0], h2[0]};
                    m_cnt = m_cnt + 1;
                    if (m_cnt == 16) begin
                        m_phase = 2;
                        m_hold  = m_sr;
                        if (!h2[3]) begin m_latch = m_sr; did_auto = 1'b1; end
                    end
                end else if (chain_en) begin
                    m_sr   = {m_sr[14:0], h2[0]};
                    m_hold = m_sr;
                end
            end
            if (!did_auto && l_fall) m_latch = old_hold;
            h3 = h2; h2 = h1; h1 = {load_n, frame_n, ser_clk, ser_data};
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk(cur_req, "dac_word vs model", dac_word, m_latch);
            chk(cur_req, "chain_out vs model", {15'd0, chain_out}, {15'd0, m_chain});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_bit(input logic b, input bit flip, output logic seen_out);
        ser_data = b;
        ser_clk  = 1'b1;
        wait_n(4);
        seen_out = chain_out;
        ser_clk  = 1'b0;
        if (flip) begin
            wait_n(1);
            ser_data = ~b;
            wait_n(3);
        end else begin
            wait_n(4);
        end
    endtask

    task automatic send_bits(input logic [31:0] v, input int n, input bit flip);
        logic dummy;
        for (int i = n - 1; i >= 0; i--) drive_bit(v[i], flip, dummy);
    endtask

    task automatic frame_open();
        frame_n = 1'b0;
        wait_n(4);
    endtask

    task automatic frame_close();
        ser_clk = 1'b1;
        wait_n(4);
        frame_n = 1'b1;
        wait_n(6);
    endtask

    task automatic strobe();
        load_n = 1'b0;
        wait_n(1);
        load_n = 1'b1;
        wait_n(6);
    endtask

    // ---------------- watchdog ----------------
    bit done = 1'b0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    // ---------------- tests ----------------
    logic        so;
    logic [15:0] tap;
    logic [63:0] chain_stream;

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        // R10 reset state
        chk("R10", "dac_word after reset", dac_word, 16'h0000);
        chk("R10", "chain_out after reset", {15'd0, chain_out}, 16'h0000);
        cmp_on = 1'b1;

        // R1 / R4: automatic update, MSB first
        cur_req = "R1";
        load_n = 1'b0;
        frame_open();
        send_bits(32'h0000_A5C3, 16, 1'b0);
        frame_close();
        chk("R1", "word MSB first", dac_word, 16'hA5C3);
        chk("R4", "auto update with load low", dac_word, 16'hA5C3);

        // R5: strobed update
        cur_req = "R5";
        load_n = 1'b1;
        wait_n(4);
        frame_open();
        send_bits(32'h0000_1234, 16, 1'b0);
        frame_close();
        chk("R5", "no update while load high", dac_word, 16'hA5C3);
        strobe();
        chk("R5", "one-cycle strobe copies word", dac_word, 16'h1234);

        // R6: partial frame dropped
        cur_req = "R6";
        frame_open();
        send_bits(32'h0000_01FF, 9, 1'b0);
        frame_close();
        chk("R6", "partial frame no latch change", dac_word, 16'h1234);
        strobe();
        chk("R6", "input register kept old word", dac_word, 16'h1234);

        // R7: two bytes in one frame
        cur_req = "R7";
        load_n = 1'b0;
        wait_n(4);
        frame_open();
        send_bits(32'h0000_005E, 8, 1'b0);
        ser_clk = 1'b1;
        wait_n(20);
        send_bits(32'h0000_0091, 8, 1'b0);
        frame_close();
        chk("R7", "two bursts equal one word", dac_word, 16'h5E91);

        // R2: data flipped after each falling edge
        cur_req = "R2";
        frame_open();
        send_bits(32'h0000_0F0F, 16, 1'b1);
        frame_close();
        chk("R2", "sampled on falling edge only", dac_word, 16'h0F0F);

        // R3: clocks with frame high ignored
        cur_req = "R3";
        send_bits(32'h0000_DEAD, 16, 1'b0);
        wait_n(6);
        chk("R3", "no capture outside frame", dac_word, 16'h0F0F);
        frame_open();
        send_bits(32'h0000_8001, 16, 1'b0);
        frame_close();
        chk("R3", "next framed word clean", dac_word, 16'h8001);

        // R9: cascade off, extra bits ignored
        cur_req = "R9";
        chain_en = 1'b0;
        load_n = 1'b1;
        wait_n(4);
        frame_open();
        send_bits(32'h000B_EEFA, 20, 1'b0);
        chk("R9", "chain_out low when cascade off", {15'd0, chain_out}, 16'h0000);
        frame_close();
        chk("R9", "no auto update with load high", dac_word, 16'h8001);
        strobe();
        chk("R9", "first 16 bits kept", dac_word, 16'hBEEF);

        // R8: cascade on, 64 clocks through the chain
        cur_req = "R8";
        chain_en = 1'b1;
        chain_stream = 64'hC001_2345_6789_ABCD;
        tap = '0;
        wait_n(4);
        frame_open();
        for (int k = 1; k <= 64; k++) begin
            drive_bit(chain_stream[64 - k], 1'b0, so);
            if (k >= 17 && k <= 32) tap = {tap[14:0], so};
        end
        frame_close();
        chk("R8", "cascade out equals first word", tap, 16'hC001);
        strobe();
        chk("R8", "last 16 bits kept", dac_word, 16'hABCD);

        // R11: latency of the automatic update
        cur_req = "R11";
        chain_en = 1'b0;
        load_n = 1'b0;
        wait_n(6);
        frame_open();
        send_bits(32'h0000_4C4C >> 1, 15, 1'b0);
        ser_data = 1'b0;
        ser_clk  = 1'b1;
        wait_n(4);
        ser_clk = 1'b0;
        wait_n(2);
        chk("R11", "unchanged after two clocks", dac_word, 16'hABCD);
        wait_n(1);
        chk("R11", "updated after three clocks", dac_word, 16'h4C4C);
        wait_n(3);
        frame_close();

        cmp_on = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule